// File: doc/BRIEF.md
# Serial Receive Byte Queue with Fill Trigger and Idle Timeout

This block sits between the receiver front end of a serial controller and the host-side register decoder. Each byte the front end deframes is presented with a one-cycle strobe and stored in a 16-entry first-in first-out queue. A host read of the data register pops the oldest byte. A host write to the control register can empty the queue with a one-cycle flush pulse.

The block tells the host that data is waiting through a data-ready flag and an optional receive interrupt. The flag is set in either of two cases. The first is when the fill level reaches a threshold chosen by a 2-bit code. The second is when bytes below that threshold have sat unread for 15 character times since the most recent byte arrived. The character time is a parameterised count of clock cycles, one bit time at 9600 baud by default.

Two small state machines carry the control. The idle timer has the states TMR_IDLE and TMR_RUN. It moves IDLE→RUN on a restart, which is a push that leaves the level under the threshold. It moves RUN→RUN with the count cleared on a further restart. It moves RUN→IDLE in three cases: on expiry, on a cancel (a threshold hit while interrupts are enabled), and on hold, which is a flush or an empty queue. The ready flag has the states FLAG_LOW and FLAG_HIGH. It moves LOW→HIGH on a threshold hit or a timer expiry. It moves HIGH→LOW on a flush, or on a pop that leaves the level under the threshold.

Top module: `rx_trig_fifo`

## Requirements
- R1: Bytes leave in arrival order; `rd_data_o` shows the oldest stored byte, and shows 0 while the queue is empty.
- R2: The queue holds DEPTH (16) bytes; a strobed byte arriving while the level is 16 is dropped and the stored contents are unchanged.
- R3: `trig_sel_i` codes 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 bytes; on the clock edge where an accepted byte brings the level to or above the threshold, `ready_o` becomes 1.
- R4: `irq_o` becomes 1 on the same edge that a threshold hit or a timer expiry sets the flag, but only while `rie_i` is 1; on any edge where `rie_i` is 0, `irq_o` is cleared to 0.
- R5: An accepted byte that leaves the level under the threshold restarts a timer of 15 × ETU_CYCLES clock cycles; `ready_o` rises that many edges after the last such byte, unless the timer was cancelled or held first.
- R6: A pop while the queue is empty changes neither the level nor `ready_o`.
- R7: A pop that leaves the level under the threshold clears `ready_o`.
- R8: A flush pulse empties the queue, clears `ready_o` and stops the timer; a byte strobed in the same cycle is dropped.
- R9: While `rx_en_i` is 0, strobed bytes are ignored.
- R10: A byte accepted in the same cycle as a pop of a non-empty, non-full queue leaves the level unchanged and keeps arrival order across pointer wrap.
- R11: While the queue is empty the timer stays idle, so a byte popped before expiry leaves `ready_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Receive enable; bytes are stored only while 1 |
| rie_i | input | 1 | Receive interrupt enable |
| trig_sel_i | input | 2 | Threshold code: 0→1, 1→4, 2→8, 3→14 bytes |
| rx_push_i | input | 1 | One-cycle strobe of a received byte |
| rx_byte_i | input | DW | Received byte |
| pop_i | input | 1 | Host read of the data register |
| flush_i | input | 1 | Queue reset pulse |
| rd_data_o | output | DW | Oldest stored byte, 0 when empty |
| level_o | output | $clog2(DEPTH+1) | Number of stored bytes |
| ready_o | output | 1 | Data-ready flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The bench walks the timer edge by edge. It re-arms the timer with a second byte halfway through the first window. It then checks that the flag is still low one cycle before the second window ends and high exactly when it ends. A design that did not restart the timer would raise the flag about 30 cycles early, and an off-by-one counter would miss the exact cycle. The bench also fills the queue, strobes a seventeenth byte and drains everything through a scoreboard. It overlaps pushes with pops across the pointer wrap, so a design that overwrites when full or drops bytes on a simultaneous push and pop would return bytes out of order. It pops an empty queue, pops a byte before the timer expires, and strobes bytes with receive disabled. A design that underflows its level or lets the timer run on an empty queue would show a wrong level or a stray ready flag.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_t;

    typedef enum logic {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_t;

    // Threshold code to byte count
    function automatic int unsigned trig_level(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [DW-1:0]                wr_data,
    input  logic                         rd_en,
    input  logic                         clear,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en && !clear) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            level <= level + CW'(wr_en) - CW'(rd_en);
        end
    end

    assign head = (level == '0) ? '0 : mem[rd_ptr];

    // R2: the level never passes the storage size
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

endmodule

// File: rtl/rxf_timer.sv
module rxf_timer
    import rxf_pkg::*;
#(
    parameter int LIMIT = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic cancel,
    input  logic hold,
    output logic expire,
    output logic busy
);
    localparam int TW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [TW-1:0] END_CNT = TW'(LIMIT - 1);

    tmr_state_t state, state_nx;
    logic [TW-1:0] cnt;
    logic stop;

    assign stop = cancel || hold;

    always_comb begin
        state_nx = state;
        unique case (state)
            TMR_IDLE: if (restart && !stop) state_nx = TMR_RUN;
            TMR_RUN: begin
                if (stop)                 state_nx = TMR_IDLE;
                else if (restart)         state_nx = TMR_RUN;
                else if (cnt == END_CNT)  state_nx = TMR_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TMR_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state_nx == TMR_RUN && !restart) cnt <= cnt + 1'b1;
            else                                 cnt <= '0;
        end
    end

    always_comb begin
        busy   = (state == TMR_RUN);
        expire = (state == TMR_RUN) && !stop && !restart && (cnt == END_CNT);
    end

    // R5: an expiry pulse returns the timer to idle
    assert_expire_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (state == TMR_IDLE));

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int DW         = 8,
    parameter int CLK_HZ     = 50_000_000,
    parameter int BAUD       = 9600,
    parameter int ETU_CYCLES = CLK_HZ / BAUD,
    parameter int CHAR_UNITS = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_en_i,
    input  logic                       rie_i,
    input  logic [1:0]                 trig_sel_i,
    input  logic                       rx_push_i,
    input  logic [DW-1:0]              rx_byte_i,
    input  logic                       pop_i,
    input  logic                       flush_i,
    output logic [DW-1:0]              rd_data_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o,
    output logic                       ready_o,
    output logic                       irq_o
);
    localparam int CW  = $clog2(DEPTH+1);
    localparam int TMO = CHAR_UNITS * ETU_CYCLES;
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic          push_ok, pop_ok, hit, drop, expire, tmr_busy;
    logic [CW-1:0] lvl_nx, thr;
    flag_state_t   flag, flag_nx;

    assign thr     = CW'(trig_level(trig_sel_i));
    assign push_ok = rx_push_i && rx_en_i && !flush_i && (level_o != FULL_LVL);
    assign pop_ok  = pop_i && !flush_i && (level_o != '0);
    assign lvl_nx  = level_o + CW'(push_ok) - CW'(pop_ok);
    assign hit     = push_ok && (lvl_nx >= thr);
    assign drop    = pop_ok && (lvl_nx < thr);

    rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_ok),
        .wr_data (rx_byte_i),
        .rd_en   (pop_ok),
        .clear   (flush_i),
        .head    (rd_data_o),
        .level   (level_o)
    );

    rxf_timer #(.LIMIT(TMO)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (push_ok && (lvl_nx < thr)),
        .cancel  (hit && rie_i),
        .hold    (flush_i || (lvl_nx == '0)),
        .expire  (expire),
        .busy    (tmr_busy)
    );

    // Ready flag state machine
    always_comb begin
        flag_nx = flag;
        unique case (flag)
            FLAG_LOW:  if (!flush_i && (hit || expire)) flag_nx = FLAG_HIGH;
            FLAG_HIGH: if (flush_i || (drop && !hit))   flag_nx = FLAG_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag  <= FLAG_LOW;
            irq_o <= 1'b0;
        end else begin
            flag <= flag_nx;
            if (!rie_i)              irq_o <= 1'b0;
            else if (hit || expire)  irq_o <= 1'b1;
        end
    end

    always_comb ready_o = (flag == FLAG_HIGH);

    // R2: a byte strobed into a full queue is dropped
    assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push_i && rx_en_i && level_o == FULL_LVL && !pop_i && !flush_i)
        |=> level_o == FULL_LVL);
    // R4: no interrupt survives an edge with interrupts disabled
    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rie_i |=> !irq_o);
    // R6: popping an empty queue changes nothing
    assert_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && level_o == '0 && !rx_push_i && !flush_i)
        |=> (level_o == '0 && $stable(ready_o)));
    // R8: flush empties and clears the flag
    assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (level_o == '0 && !ready_o));
    // R9: receive disabled keeps the level
    assert_rx_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en_i && !pop_i && !flush_i) |=> $stable(level_o));
    // R10: simultaneous push and pop hold the level
    assert_push_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push_i && rx_en_i && pop_i && !flush_i &&
         level_o != '0 && level_o != FULL_LVL) |=> $stable(level_o));
    // R11: timer idle while the queue is empty
    assert_idle_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == '0) |-> !tmr_busy);

endmodule

// File: tb/tb_rx_trig_fifo.sv
module tb_rx_trig_fifo;
    localparam int ETU = 4;
    localparam int TMO = 15 * ETU;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, rie = 1'b0, rx_push = 1'b0, pop = 1'b0, flush = 1'b0;
    logic [1:0] trig = 2'd0;
    logic [7:0] rx_byte = '0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       ready, irq;

    int nvec = 0, nbad = 0;
    logic [7:0] q[$];

    always #10 clk = ~clk;

    rx_trig_fifo #(.ETU_CYCLES(ETU)) dut (
        .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .rie_i(rie),
        .trig_sel_i(trig), .rx_push_i(rx_push), .rx_byte_i(rx_byte),
        .pop_i(pop), .flush_i(flush), .rd_data_o(rd_data),
        .level_o(level), .ready_o(ready), .irq_o(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: compares the head byte on every pop against the scoreboard
    always @(negedge clk) begin
        if (rst_n && pop) begin
            if (q.size() > 0) begin
                chk("R1 head byte", rd_data, q[0]);
                void'(q.pop_front());
            end else begin
                chk("R6 empty head", rd_data, 0);
            end
        end
    end

    task automatic step(input logic do_push, input logic [7:0] b, input logic do_pop);
        bit acc;
        acc = do_push && rx_en && (q.size() < 16);
        rx_push = do_push; rx_byte = b; pop = do_pop;
        @(posedge clk); #1;
        rx_push = 1'b0; pop = 1'b0;
        if (acc) q.push_back(b);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
        q.delete();
    endtask

    initial begin
        #(200000 * 20);
        nbad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 reset level", level, 0);
        chk("R1 reset head", rd_data, 0);
        chk("R3 reset ready", ready, 0);
        chk("R4 reset irq", irq, 0);

        // R3/R4/R7: threshold 4 with interrupts
        rx_en = 1'b1; rie = 1'b1; trig = 2'd1;
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 8'h11 + 8'(i), 1'b0);
            chk("R3 below threshold", ready, 0);
        end
        step(1'b1, 8'h14, 1'b0);
        chk("R3 level", level, 4);
        chk("R3 ready at threshold", ready, 1);
        chk("R4 irq at threshold", irq, 1);
        step(1'b0, 8'h00, 1'b1);
        chk("R7 ready after pop", ready, 0);
        chk("R7 irq kept", irq, 1);
        rie = 1'b0; idle(1);
        chk("R4 irq cleared", irq, 0);
        rie = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b1);
        chk("R1 drained", level, 0);

        // R5: timeout re-armed by a second byte
        trig = 2'd3;
        step(1'b1, 8'hA1, 1'b0);
        idle(30);
        step(1'b1, 8'hA2, 1'b0);
        idle(TMO - 1);
        chk("R5 before expiry", ready, 0);
        idle(1);
        chk("R5 ready at expiry", ready, 1);
        chk("R5 irq at expiry", irq, 1);

        // R8: flush
        do_flush();
        chk("R8 level", level, 0);
        chk("R8 ready", ready, 0);
        rie = 1'b0; idle(1); rie = 1'b1;

        // R11: empty queue stops the timer
        step(1'b1, 8'hB1, 1'b0);
        step(1'b0, 8'h00, 1'b1);
        idle(TMO + 10);
        chk("R11 no ready", ready, 0);
        chk("R11 level", level, 0);

        // R6: pop when empty
        step(1'b0, 8'h00, 1'b1);
        chk("R6 level", level, 0);
        chk("R6 ready", ready, 0);

        // R9: receive disabled
        rx_en = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b1, 8'hC0 + 8'(i), 1'b0);
        chk("R9 level", level, 0);
        rx_en = 1'b1;

        // R2/R10: fill, overflow, wrap with simultaneous push and pop
        trig = 2'd0; rie = 1'b0;
        for (int i = 0; i < 16; i++) step(1'b1, 8'h40 + 8'(i), 1'b0);
        chk("R2 full level", level, 16);
        chk("R3 ready thr1", ready, 1);
        chk("R4 irq masked", irq, 0);
        step(1'b1, 8'hEE, 1'b0);
        chk("R2 dropped", level, 16);
        step(1'b0, 8'h00, 1'b1);
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 8'h80 + 8'(i), 1'b1);
            chk("R10 level held", level, 15);
        end
        for (int i = 0; i < 15; i++) step(1'b0, 8'h00, 1'b1);
        chk("R10 drained", level, 0);
        chk("R7 ready drained", ready, 0);
        chk("R1 scoreboard empty", q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule